// File: doc/BRIEF.md
# Power-Save Wakeup Controller

This block manages the low-power states of a processor core. A hypervisor-privileged command asks to enter one of four power-save levels: doze, nap, sleep or deep-winkle. The command halts the core and raises an internal power-save flag. The command is refused with a privilege fault when the core is not in hypervisor mode.

While the core is halted, the block watches a vector of pending interrupt sources. Each source is gated by an enable bit taken from a 64-bit partition control word. The word is read in one of two layouts: an extended layout with five enables, or a legacy layout with three. When an enabled source is pending together with the hard interrupt request, the core leaves power-save. The block then emits a one-cycle exception request with a target vector and a saved-status word.

Every wake except a machine check is steered to the system-reset vector, with a 4-bit code naming the cause. A machine check keeps its own vector. When several enabled sources are pending at once, a fixed priority picks the cause. A wake from a source that has no cause code is reported as an error rather than as an exception.

Top module: `psw_wake_top`

## Requirements
- R1: After reset, `halted`, `eeSet`, `privFault`, `wakeReq`, `eeClr` and `wakeErr` are 0, `psLevel` is 0 and `wakeVec` and `wakeStatus` are all zero.
- R2: A command (`cmdValid`) seen while running with `hvMode` high halts the core from the next cycle. It pulses `eeSet` for one cycle, and `psLevel` shows the command code: 0 doze, 1 nap, 2 sleep, 3 deep-winkle.
- R3: A command seen while running with `hvMode` low pulses `privFault` for one cycle, and the core keeps running.
- R4: While halted, no wake happens unless `hardReq` is high and at least one pending source has its enable set. Otherwise `halted` stays 1.
- R5: Enable bits use big-endian numbering, where bit n is `partCtl[63-n]`. In the extended layout (`extLayout`=1) the enables are: bit 47 doorbell, bit 48 hypervisor doorbell, bit 49 external, bit 50 decrementer, and bit 51 machine check, hypervisor maintenance and auxiliary. The `pendSrc` index order is 0 reset, 1 machine check, 2 hypervisor maintenance, 3 external, 4 decrementer, 5 hypervisor doorbell, 6 doorbell, 7 auxiliary.
- R6: In the legacy layout (`extLayout`=0), bits 47 and 48 are ignored and neither doorbell can wake the core. Bits 49 to 51 act as in R5.
- R7: A pending reset source wakes a halted core when `hardReq` is high, whatever the enable bits hold.
- R8: A wake for any cause other than machine check behaves as follows one cycle after the triggering edge:
  - it pulses `wakeReq` and `eeClr` for one cycle and clears `halted`;
  - it sets `wakeVec` to 0x100;
  - it sets `wakeStatus` bit 16 (big-endian bit 47) and places the cause code in `wakeStatus[21:18]` (big-endian bits 42 to 45). The codes are reset 0x4, external 0x8, decrementer 0x6, doorbell 0x5, hypervisor doorbell 0x3, hypervisor maintenance 0xA.
- R9: A machine-check wake pulses `wakeReq` with `wakeVec` = 0x200. `wakeStatus` has only bit 16 set, and `eeClr` stays 0.
- R10: With several enabled sources pending, the cause is chosen in the order reset, machine check, hypervisor maintenance, external, decrementer, hypervisor doorbell, doorbell.
- R11: A wake won by the auxiliary source (index 7, which has no cause code) pulses `wakeErr` for one cycle with no `wakeReq`, and leaves power-save.
- R12: `hasWork` equals `msrEe` AND `hardReq` while running. While halted it is high exactly when the wake condition of R4/R7 holds.
- R13: While halted, commands are ignored: no `privFault`, no `eeSet`, and `psLevel` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Power-save entry command strobe |
| cmdKind | input | 2 | Requested level code |
| hvMode | input | 1 | Core is in hypervisor mode |
| msrEe | input | 1 | Machine-status external-enable bit |
| partCtl | input | 64 | Partition control word holding wake enables |
| extLayout | input | 1 | 1 selects the extended enable layout |
| hardReq | input | 1 | Hard interrupt request |
| pendSrc | input | 8 | Pending interrupt sources |
| halted | output | 1 | Core halted in power-save |
| psLevel | output | 2 | Level of the last accepted entry |
| eeSet | output | 1 | Force external-enable to 1 (entry pulse) |
| privFault | output | 1 | Privilege fault pulse |
| hasWork | output | 1 | Core has work to do |
| wakeReq | output | 1 | Exception request pulse on wake |
| wakeVec | output | 16 | Exception vector of the last wake |
| wakeStatus | output | 64 | Saved-status word of the last wake |
| eeClr | output | 1 | Clear external-enable (redirected wake pulse) |
| wakeErr | output | 1 | Wake by a source with no cause code |

## Verification
The properties assume that `pendSrc`, `hardReq`, `partCtl` and `extLayout` are steady across each sampling edge. They also assume that `cmdValid` is a single-cycle strobe driven away from the edge. The stimulus drives every input on the falling clock edge and holds it for at least one full cycle. The stimulus also sets up the partition word and layout before each entry command and keeps them unchanged until the wake is observed, so the enable mask in force at the wake edge is known.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int REG_W = 64;
  localparam int SRC_N = 8;
  localparam int CODE_W = 4;

  // source indices, also their wake priority (lower index wins)
  localparam int SRC_RESET = 0;
  localparam int SRC_MCHK = 1;
  localparam int SRC_HMAINT = 2;
  localparam int SRC_EXT = 3;
  localparam int SRC_DEC = 4;
  localparam int SRC_HDBELL = 5;
  localparam int SRC_DBELL = 6;
  localparam int SRC_AUX = 7;

  // big-endian enable bit numbers
  localparam int BE_DBELL = 47;
  localparam int BE_HDBELL = 48;
  localparam int BE_EXT = 49;
  localparam int BE_DEC = 50;
  localparam int BE_MCHK = 51;

  // big-endian positions in the saved status
  localparam int BE_DOZE_FLAG = 47;
  localparam int BE_CAUSE_LSB = 45;

  typedef enum logic [1:0] {
    LVL_DOZE = 2'd0,
    LVL_NAP = 2'd1,
    LVL_SLEEP = 2'd2,
    LVL_WINKLE = 2'd3
  } psLevel_e;

  typedef struct packed {
    logic enter;
    logic privErr;
    logic wakeOk;
    logic wakeBad;
  } ctlStb_t;

  function automatic int leBit(input int beIdx);
    return REG_W - 1 - beIdx;
  endfunction
endpackage

// File: rtl/psw_enable_map.sv
module psw_enable_map
  import psw_pkg::*;
(
  input  logic [REG_W-1:0] partCtl,
  input  logic             extLayout,
  output logic [SRC_N-1:0] enMask
);
  localparam int LE_DBELL = REG_W - 1 - BE_DBELL;
  localparam int LE_HDBELL = REG_W - 1 - BE_HDBELL;
  localparam int LE_EXT = REG_W - 1 - BE_EXT;
  localparam int LE_DEC = REG_W - 1 - BE_DEC;
  localparam int LE_MCHK = REG_W - 1 - BE_MCHK;

  always_comb begin
    enMask = '0;
    enMask[SRC_RESET] = 1'b1;
    enMask[SRC_MCHK] = partCtl[LE_MCHK];
    enMask[SRC_HMAINT] = partCtl[LE_MCHK];
    enMask[SRC_AUX] = partCtl[LE_MCHK];
    enMask[SRC_EXT] = partCtl[LE_EXT];
    enMask[SRC_DEC] = partCtl[LE_DEC];
    enMask[SRC_HDBELL] = extLayout & partCtl[LE_HDBELL];
    enMask[SRC_DBELL] = extLayout & partCtl[LE_DBELL];
  end
endmodule

// File: rtl/psw_cause_pick.sv
module psw_cause_pick
  import psw_pkg::*;
#(
  localparam int IDX_W = $clog2(SRC_N)
) (
  input  logic [SRC_N-1:0]  liveSrc,
  output logic              anyHit,
  output logic [IDX_W-1:0]  winIdx,
  output logic [CODE_W-1:0] causeCode,
  output logic              hasCode,
  output logic              isMchk
);
  always_comb begin
    winIdx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (liveSrc[i]) winIdx = IDX_W'(i);
    end
    anyHit = |liveSrc;
  end

  always_comb begin
    causeCode = '0;
    hasCode = 1'b1;
    isMchk = 1'b0;
    case (int'(winIdx))
      SRC_RESET:  causeCode = 4'h4;
      SRC_MCHK:   isMchk = 1'b1;
      SRC_HMAINT: causeCode = 4'hA;
      SRC_EXT:    causeCode = 4'h8;
      SRC_DEC:    causeCode = 4'h6;
      SRC_HDBELL: causeCode = 4'h3;
      SRC_DBELL:  causeCode = 4'h5;
      default:    hasCode = 1'b0;
    endcase
  end
endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'h0100,
  parameter logic [VEC_W-1:0] MCHK_VEC = 16'h0200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] partCtl,
  input  logic             extLayout,
  input  logic             hardReq,
  input  logic [SRC_N-1:0] pendSrc,
  input  ctlStb_t          stb,
  output logic             wakeHit,
  output logic             noCode,
  output logic             wakeReq,
  output logic [VEC_W-1:0] wakeVec,
  output logic [REG_W-1:0] wakeStatus,
  output logic             eeClr,
  output logic             wakeErr
);
  localparam int IDX_W = $clog2(SRC_N);
  localparam int LE_DOZE = REG_W - 1 - BE_DOZE_FLAG;
  localparam int LE_CAUSE = REG_W - 1 - BE_CAUSE_LSB;

  logic [SRC_N-1:0]  enMask;
  logic [SRC_N-1:0]  liveSrc;
  logic              anyHit;
  logic [IDX_W-1:0]  winIdx;
  logic [CODE_W-1:0] causeCode;
  logic              hasCode;
  logic              isMchk;
  logic [REG_W-1:0]  nextStatus;
  logic [VEC_W-1:0]  nextVec;

  psw_enable_map enMap_i (
    .partCtl(partCtl),
    .extLayout(extLayout),
    .enMask(enMask)
  );

  assign liveSrc = pendSrc & enMask & {SRC_N{hardReq}};

  psw_cause_pick pick_i (
    .liveSrc(liveSrc),
    .anyHit(anyHit),
    .winIdx(winIdx),
    .causeCode(causeCode),
    .hasCode(hasCode),
    .isMchk(isMchk)
  );

  assign wakeHit = anyHit;
  assign noCode = ~hasCode;

  always_comb begin
    nextStatus = '0;
    nextStatus[LE_DOZE] = 1'b1;
    if (!isMchk) nextStatus[LE_CAUSE +: CODE_W] = causeCode;
    nextVec = isMchk ? MCHK_VEC : RESET_VEC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeReq <= 1'b0;
      eeClr <= 1'b0;
      wakeErr <= 1'b0;
      wakeVec <= '0;
      wakeStatus <= '0;
    end else begin
      wakeReq <= stb.wakeOk;
      eeClr <= stb.wakeOk & ~isMchk;
      wakeErr <= stb.wakeBad;
      if (stb.wakeOk) begin
        wakeVec <= nextVec;
        wakeStatus <= nextStatus;
      end
    end
  end
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  input  logic       hvMode,
  input  logic       msrEe,
  input  logic       hardReq,
  input  logic       wakeHit,
  input  logic       noCode,
  output ctlStb_t    stb,
  output logic       halted,
  output logic [1:0] psLevel,
  output logic       eeSet,
  output logic       privFault,
  output logic       hasWork
);
  typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} state_e;
  state_e   state;
  psLevel_e level;

  always_comb begin
    stb.enter = (state == ST_RUN) & cmdValid & hvMode;
    stb.privErr = (state == ST_RUN) & cmdValid & ~hvMode;
    stb.wakeOk = (state == ST_HALT) & wakeHit & ~noCode;
    stb.wakeBad = (state == ST_HALT) & wakeHit & noCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      level <= LVL_DOZE;
      eeSet <= 1'b0;
      privFault <= 1'b0;
    end else begin
      eeSet <= stb.enter;
      privFault <= stb.privErr;
      if (stb.enter) begin
        state <= ST_HALT;
        level <= psLevel_e'(cmdKind);
      end else if (stb.wakeOk || stb.wakeBad) begin
        state <= ST_RUN;
      end
    end
  end

  assign halted = (state == ST_HALT);
  assign psLevel = level;
  assign hasWork = halted ? wakeHit : (msrEe & hardReq);
endmodule

// File: rtl/psw_wake_top.sv
module psw_wake_top
  import psw_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'h0100,
  parameter logic [VEC_W-1:0] MCHK_VEC = 16'h0200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdKind,
  input  logic             hvMode,
  input  logic             msrEe,
  input  logic [REG_W-1:0] partCtl,
  input  logic             extLayout,
  input  logic             hardReq,
  input  logic [SRC_N-1:0] pendSrc,
  output logic             halted,
  output logic [1:0]       psLevel,
  output logic             eeSet,
  output logic             privFault,
  output logic             hasWork,
  output logic             wakeReq,
  output logic [VEC_W-1:0] wakeVec,
  output logic [REG_W-1:0] wakeStatus,
  output logic             eeClr,
  output logic             wakeErr
);
  ctlStb_t stb;
  logic    wakeHit;
  logic    noCode;

  psw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .hvMode(hvMode), .msrEe(msrEe), .hardReq(hardReq),
    .wakeHit(wakeHit), .noCode(noCode), .stb(stb), .halted(halted),
    .psLevel(psLevel), .eeSet(eeSet), .privFault(privFault),
    .hasWork(hasWork)
  );

  psw_datapath #(
    .VEC_W(VEC_W), .RESET_VEC(RESET_VEC), .MCHK_VEC(MCHK_VEC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .partCtl(partCtl), .extLayout(extLayout),
    .hardReq(hardReq), .pendSrc(pendSrc), .stb(stb), .wakeHit(wakeHit),
    .noCode(noCode), .wakeReq(wakeReq), .wakeVec(wakeVec),
    .wakeStatus(wakeStatus), .eeClr(eeClr), .wakeErr(wakeErr)
  );
endmodule

// File: rtl/psw_chk.sv
module psw_chk
  import psw_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'h0100,
  parameter logic [VEC_W-1:0] MCHK_VEC = 16'h0200
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             hvMode,
  input logic             hardReq,
  input logic [SRC_N-1:0] pendSrc,
  input logic             halted,
  input logic [1:0]       psLevel,
  input logic             eeSet,
  input logic             privFault,
  input logic             wakeReq,
  input logic [VEC_W-1:0] wakeVec,
  input logic [REG_W-1:0] wakeStatus,
  input logic             eeClr,
  input logic             wakeErr
);
  // R2
  entry_hv_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && hvMode && !halted |=> halted && eeSet);
  // R3
  entry_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !hvMode && !halted |=> privFault && !halted);
  // R4
  no_hard_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted && !hardReq |=> halted && !wakeReq && !wakeErr);
  // R7
  reset_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted && hardReq && pendSrc[SRC_RESET] |=> wakeReq && !halted);
  // R8
  redir_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq && wakeVec == RESET_VEC |-> eeClr && wakeStatus[16] && !halted);
  // R9
  mchk_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq && wakeVec == MCHK_VEC |-> !eeClr && wakeStatus[21:18] == 4'h0);
  // R11
  wake_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wakeReq && wakeErr));
  // R13
  held_lvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(psLevel) && !privFault);
endmodule

bind psw_wake_top psw_chk #(
  .VEC_W(VEC_W), .RESET_VEC(RESET_VEC), .MCHK_VEC(MCHK_VEC)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .hvMode(hvMode),
  .hardReq(hardReq), .pendSrc(pendSrc), .halted(halted),
  .psLevel(psLevel), .eeSet(eeSet), .privFault(privFault),
  .wakeReq(wakeReq), .wakeVec(wakeVec), .wakeStatus(wakeStatus),
  .eeClr(eeClr), .wakeErr(wakeErr)
);

// File: tb/psw_wake_top_tb_top.sv
module psw_wake_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;
  // kinds: 0 stays halted, 1 redirected, 2 machine check, 3 error
  // fields: ext[19], en[18:14] (bits 47..51), pend[13:6], kind[5:4], cause[3:0]
  localparam logic [19:0] VT [NVEC] = '{
    {1'b1, 5'b11111, 8'h08, 2'd1, 4'h8},  // R5 external
    {1'b1, 5'b11111, 8'h10, 2'd1, 4'h6},  // R5 decrementer
    {1'b1, 5'b11111, 8'h40, 2'd1, 4'h5},  // R5 doorbell
    {1'b1, 5'b11111, 8'h20, 2'd1, 4'h3},  // R5 hyp doorbell
    {1'b1, 5'b11111, 8'h04, 2'd1, 4'hA},  // R5 hyp maintenance
    {1'b1, 5'b11111, 8'h02, 2'd2, 4'h0},  // R9 machine check
    {1'b1, 5'b00000, 8'h01, 2'd1, 4'h4},  // R7 reset, no enables
    {1'b1, 5'b00000, 8'h08, 2'd0, 4'h0},  // R4 disabled external
    {1'b0, 5'b11111, 8'h40, 2'd0, 4'h0},  // R6 legacy doorbell
    {1'b0, 5'b11111, 8'h20, 2'd0, 4'h0},  // R6 legacy hyp doorbell
    {1'b0, 5'b00100, 8'h08, 2'd1, 4'h8},  // R6 legacy external
    {1'b1, 5'b10000, 8'h40, 2'd1, 4'h5},  // R5 only bit 47
    {1'b1, 5'b01111, 8'h40, 2'd0, 4'h0},  // R5 bit 47 clear
    {1'b1, 5'b11111, 8'h7E, 2'd2, 4'h0},  // R10 mchk first
    {1'b1, 5'b11111, 8'h7C, 2'd1, 4'hA},  // R10 hmaint next
    {1'b1, 5'b11111, 8'h78, 2'd1, 4'h8},  // R10 external next
    {1'b1, 5'b11111, 8'h70, 2'd1, 4'h6},  // R10 decrementer next
    {1'b1, 5'b11111, 8'h60, 2'd1, 4'h3},  // R10 hyp doorbell over doorbell
    {1'b1, 5'b11111, 8'hFF, 2'd1, 4'h4},  // R10 reset over all
    {1'b1, 5'b11111, 8'h80, 2'd3, 4'h0},  // R11 auxiliary
    {1'b1, 5'b11110, 8'h80, 2'd0, 4'h0},  // R11 auxiliary disabled
    {1'b1, 5'b11011, 8'h18, 2'd1, 4'h6}   // R5 external disabled, dec wins
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdKind = 2'd0;
  logic        hvMode = 1'b1;
  logic        msrEe = 1'b0;
  logic [63:0] partCtl = '0;
  logic        extLayout = 1'b1;
  logic        hardReq = 1'b0;
  logic [7:0]  pendSrc = '0;
  logic        halted, eeSet, privFault, hasWork, wakeReq, eeClr, wakeErr;
  logic [1:0]  psLevel;
  logic [15:0] wakeVec;
  logic [63:0] wakeStatus;

  int total = 0;
  int bad = 0;
  bit done = 0;

  psw_wake_top dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .hvMode(hvMode), .msrEe(msrEe), .partCtl(partCtl),
    .extLayout(extLayout), .hardReq(hardReq), .pendSrc(pendSrc),
    .halted(halted), .psLevel(psLevel), .eeSet(eeSet),
    .privFault(privFault), .hasWork(hasWork), .wakeReq(wakeReq),
    .wakeVec(wakeVec), .wakeStatus(wakeStatus), .eeClr(eeClr),
    .wakeErr(wakeErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input int i);
    if (i == 5) return "R9";
    if (i == 6) return "R7";
    if (i == 7) return "R4";
    if (i >= 8 && i <= 10) return "R6";
    if (i >= 13 && i <= 18) return "R10";
    if (i == 19 || i == 20) return "R11";
    return "R5";
  endfunction

  function automatic logic [63:0] enWord(input logic [4:0] en);
    logic [63:0] w = '0;
    w[16] = en[4];
    w[15] = en[3];
    w[14] = en[2];
    w[13] = en[1];
    w[12] = en[0];
    return w;
  endfunction

  task automatic enter(input logic [1:0] kind, input logic hv);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdKind = kind;
    hvMode = hv;
    @(posedge clk);
    #1;
    @(negedge clk);
    cmdValid = 1'b0;
    hvMode = 1'b1;
  endtask

  task automatic resetWake();
    @(negedge clk);
    pendSrc = 8'h01;
    hardReq = 1'b1;
    @(negedge clk);
    pendSrc = '0;
    hardReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 halted", 64'(halted), 64'd0);
    chk("R1 pulses", 64'({eeSet, privFault, wakeReq, eeClr, wakeErr}), 64'd0);
    chk("R1 status", wakeStatus, 64'd0);
    chk("R1 vec", 64'(wakeVec), 64'd0);
    chk("R1 level", 64'(psLevel), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R12 running work indication
    @(negedge clk);
    msrEe = 1'b1;
    hardReq = 1'b1;
    #1;
    chk("R12 work ee=1", 64'(hasWork), 64'd1);
    msrEe = 1'b0;
    #1;
    chk("R12 work ee=0", 64'(hasWork), 64'd0);
    hardReq = 1'b0;

    // R3 privilege fault
    @(negedge clk);
    cmdValid = 1'b1;
    hvMode = 1'b0;
    @(posedge clk);
    #1;
    chk("R3 fault", 64'(privFault), 64'd1);
    chk("R3 running", 64'(halted), 64'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    hvMode = 1'b1;
    @(posedge clk);
    #1;
    chk("R3 one cycle", 64'(privFault), 64'd0);

    // R2 entry, each level code
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmdValid = 1'b1;
      cmdKind = 2'(k);
      @(posedge clk);
      #1;
      chk("R2 halted", 64'(halted), 64'd1);
      chk("R2 eeSet", 64'(eeSet), 64'd1);
      chk("R2 level", 64'(psLevel), 64'(k));
      @(negedge clk);
      cmdValid = 1'b0;
      @(posedge clk);
      #1;
      chk("R2 eeSet pulse", 64'(eeSet), 64'd0);
      resetWake();
    end

    // R13 commands ignored while halted
    enter(2'd2, 1'b1);
    @(negedge clk);
    cmdValid = 1'b1;
    hvMode = 1'b0;
    @(posedge clk);
    #1;
    chk("R13 no fault", 64'(privFault), 64'd0);
    chk("R13 halted", 64'(halted), 64'd1);
    @(negedge clk);
    hvMode = 1'b1;
    cmdKind = 2'd0;
    @(posedge clk);
    #1;
    chk("R13 level held", 64'(psLevel), 64'd2);
    chk("R13 no eeSet", 64'(eeSet), 64'd0);
    @(negedge clk);
    cmdValid = 1'b0;

    // R12 halted work indication follows wake condition
    partCtl = '0;
    pendSrc = 8'h08;
    hardReq = 1'b1;
    #1;
    chk("R12 halted masked", 64'(hasWork), 64'd0);
    partCtl = enWord(5'b00100);
    #1;
    chk("R12 halted enabled", 64'(hasWork), 64'd1);
    pendSrc = '0;
    hardReq = 1'b0;
    resetWake();

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [19:0] v = VT[i];
      string t = tagFor(i);
      @(negedge clk);
      extLayout = v[19];
      partCtl = enWord(v[18:14]);
      enter(2'(i % 4), 1'b1);
      chk({t, " entered"}, 64'(halted), 64'd1);
      @(negedge clk);
      pendSrc = v[13:6];
      hardReq = 1'b1;
      @(posedge clk);
      #1;
      case (v[5:4])
        2'd0: begin
          chk({t, " stay halted"}, 64'(halted), 64'd1);
          chk({t, " no wake"}, 64'({wakeReq, wakeErr}), 64'd0);
        end
        2'd1: begin
          chk({t, " R8 wakeReq"}, 64'(wakeReq), 64'd1);
          chk({t, " R8 vec"}, 64'(wakeVec), 64'h100);
          chk({t, " R8 status"}, wakeStatus, (64'd1 << 16) | (64'(v[3:0]) << 18));
          chk({t, " R8 eeClr"}, 64'(eeClr), 64'd1);
          chk({t, " R8 running"}, 64'(halted), 64'd0);
        end
        2'd2: begin
          chk({t, " wakeReq"}, 64'(wakeReq), 64'd1);
          chk({t, " vec"}, 64'(wakeVec), 64'h200);
          chk({t, " status"}, wakeStatus, 64'd1 << 16);
          chk({t, " eeClr"}, 64'(eeClr), 64'd0);
        end
        default: begin
          chk({t, " err"}, 64'(wakeErr), 64'd1);
          chk({t, " no req"}, 64'(wakeReq), 64'd0);
          chk({t, " running"}, 64'(halted), 64'd0);
        end
      endcase
      @(negedge clk);
      pendSrc = '0;
      hardReq = 1'b0;
      @(posedge clk);
      #1;
      chk({t, " R8 pulse ends"}, 64'({wakeReq, wakeErr, eeClr}), 64'd0);
      if (v[5:4] == 2'd0) begin
        partCtl = '0;
        resetWake();
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule